// File: doc/BRIEF.md
# Byte-Wide External Memory DMA Engine

This engine moves words between an 8-bit external byte memory and the on-chip program or data memory while the processor keeps executing. Each on-chip word is built from, or split into, one, two or three byte accesses. The on-chip memory is reached through a request/grant port. The engine asks for exactly one processor cycle per word and performs the on-chip read or write in the granted cycle.

Software sets up the transfer on the configuration inputs. These give the on-chip start address, a 14-bit external offset, an 8-bit external page, the direction, the data format, the halt choice and the wait-state count. Software then writes a nonzero word count, and that write latches the setup and starts the engine. The external byte address is the page number joined above the offset. It advances by one for every byte and carries from the offset into the page. The count is readable at all times, falls by one per finished word, and a one-cycle completion pulse marks its arrival at zero.

Top module: `bytemem_dma`

## Requirements
- R1: On a load, format code 00 writes a 24-bit program word built as {b0,b1,b2}; code 01 writes a data word {8'h00,b0,b1}; code 10 writes {8'h00,b0,8'h00}; code 11 writes {16'h0000,b0}. Here b0 is the first byte read. The program-memory select is high only for code 00.
- R2: On a store, the bytes of each on-chip word go out most significant first. Code 00 sends bits 23:16, 15:8 and 7:0. Code 01 sends bits 15:8 and 7:0. Code 10 sends only bits 15:8. Code 11 sends only bits 7:0.
- R3: The external address is {page, offset}. It starts at the programmed values and increases by one per byte. An offset overflow increments the page, and the 22-bit address wraps to zero after all ones.
- R4: Writing the count with a nonzero value while idle starts a transfer. Writing zero starts nothing: no strobe, no request, no halt and no interrupt follow.
- R5: The readable count equals the programmed count minus the number of finished words. It steps down by exactly one per word.
- R6: When the last word finishes, the count reads zero, the engine returns to idle and `done_irq` is high for exactly one cycle.
- R7: Each byte access holds its read or write strobe for wait+1 consecutive cycles, and the address stays stable over those cycles.
- R8: Each word uses exactly one granted request cycle. The request stays high with a stable address until granted. The on-chip address starts at the programmed value and increases by one per word, wrapping at 14 bits.
- R9: Direction 0 loads: read strobes, on-chip writes. Direction 1 stores: write strobes with the data bus enabled, on-chip reads.
- R10: With the halt bit set, `halt_cpu` is high from the start edge until the transfer completes. With the bit clear, it stays low.
- R11: The external data output enable is high only during store strobe cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_int_addr | input | 14 | On-chip start address |
| cfg_ext_off | input | 14 | External start offset |
| cfg_ext_page | input | 8 | External start page |
| cfg_dir | input | 1 | 0 = load into on-chip memory, 1 = store to external memory |
| cfg_fmt | input | 2 | Data format code |
| cfg_halt | input | 1 | Hold the processor halted during the transfer |
| cfg_wait | input | 3 | Wait states per byte access |
| cnt_we | input | 1 | Word-count write strobe |
| cnt_wdata | input | 14 | Word count written |
| cnt_rdata | output | 14 | Live remaining word count |
| ext_addr | output | 22 | External byte address |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_oe | output | 1 | External data bus drive enable |
| ext_wdata | output | 8 | Byte driven on stores |
| ext_rdata | input | 8 | Byte returned on loads |
| mem_req | output | 1 | Cycle-steal request to the core |
| mem_gnt | input | 1 | Core grants the stolen cycle |
| mem_pm | output | 1 | Selects program memory (else data memory) |
| mem_we | output | 1 | On-chip write in the granted cycle |
| mem_addr | output | 14 | On-chip address |
| mem_wdata | output | 24 | On-chip write word |
| mem_rdata | input | 24 | On-chip read word, valid in the granted cycle |
| halt_cpu | output | 1 | Processor halt request |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a byte sequence that crosses an offset overflow into the next page. It gets harder when that crossing falls in the middle of a multi-byte word while the on-chip address also wraps and the grant is held back. The sweep reaches this by starting every transfer a few bytes below the top of the offset range with the on-chip address just below its wrap. The grant is denied on every third cycle. One extra run starts at the very top of the last page, so the full 22-bit address wraps to zero.

// File: rtl/bytemem_dma_pkg.sv
package bytemem_dma_pkg;

  typedef enum logic [1:0] {
    FMT_PM24   = 2'b00,
    FMT_DM16   = 2'b01,
    FMT_DM8_HI = 2'b10,
    FMT_DM8_LO = 2'b11
  } xfer_fmt_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_BYTE  = 2'd1,
    S_STEAL = 2'd2
  } eng_state_e;

  // number of external byte accesses that make one on-chip word
  function automatic logic [1:0] fmt_bytes(xfer_fmt_e f);
    case (f)
      FMT_PM24: return 2'd3;
      FMT_DM16: return 2'd2;
      default:  return 2'd1;
    endcase
  endfunction

  // accumulator holds the bytes read so far, newest in bits 7:0
  function automatic logic [23:0] fmt_pack(xfer_fmt_e f, logic [23:0] acc);
    case (f)
      FMT_PM24:   return acc;
      FMT_DM16:   return {8'h00, acc[15:0]};
      FMT_DM8_HI: return {8'h00, acc[7:0], 8'h00};
      default:    return {16'h0000, acc[7:0]};
    endcase
  endfunction

  // byte number idx (0 = first sent) of an on-chip word
  function automatic logic [7:0] fmt_unpack(xfer_fmt_e f, logic [23:0] w, logic [1:0] idx);
    logic [1:0] lane;
    case (f)
      FMT_PM24:   lane = 2'd2 - idx;
      FMT_DM16:   lane = 2'd1 - idx;
      FMT_DM8_HI: lane = 2'd1;
      default:    lane = 2'd0;
    endcase
    return w[lane*8 +: 8];
  endfunction

endpackage

// File: rtl/bdma_addr_gen.sv
module bdma_addr_gen #(
  parameter int OFF_W   = 14,
  parameter int PAGE_W  = 8,
  parameter int IADDR_W = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [PAGE_W-1:0]         page_init,
  input  logic [OFF_W-1:0]          off_init,
  input  logic [IADDR_W-1:0]        int_init,
  input  logic                      byte_step,
  input  logic                      word_step,
  output logic [OFF_W+PAGE_W-1:0]   ext_addr,
  output logic [IADDR_W-1:0]        int_addr
);
  localparam int EXT_W = OFF_W + PAGE_W;

  logic [OFF_W-1:0]   off_q;
  logic [PAGE_W-1:0]  page_q;
  logic [IADDR_W-1:0] int_q;
  logic [OFF_W:0]     off_sum;
  logic               off_wrap;

  function automatic logic [OFF_W:0] off_inc(logic [OFF_W-1:0] o);
    return {1'b0, o} + 1'b1;
  endfunction

  assign off_sum  = off_inc(off_q);
  assign off_wrap = off_sum[OFF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      page_q <= '0;
      int_q  <= '0;
    end else if (load) begin
      off_q  <= off_init;
      page_q <= page_init;
      int_q  <= int_init;
    end else begin
      if (byte_step) begin
        off_q <= off_sum[OFF_W-1:0];
        if (off_wrap) page_q <= page_q + 1'b1;
      end
      if (word_step) int_q <= int_q + 1'b1;
    end
  end

  assign ext_addr = {page_q, off_q};
  assign int_addr = int_q;

  p_ext_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_step && !load) |=> ext_addr == EXT_W'($past(ext_addr) + 1'b1));

  p_page_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_step && !load && (&off_q)) |=> (off_q == '0) && (page_q == PAGE_W'($past(page_q) + 1'b1)));

  p_int_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_step && !load) |=> int_addr == IADDR_W'($past(int_addr) + 1'b1));

endmodule

// File: rtl/bdma_wait_timer.sv
module bdma_wait_timer #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              last
);
  logic [WAIT_W-1:0] cnt_q;

  assign last = active && (cnt_q == wait_cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!active || last)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q <= wait_cfg));

  p_wait_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last) |=> (cnt_q == WAIT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/bdma_packer.sv
module bdma_packer
  import bytemem_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  xfer_fmt_e   fmt,
  input  logic        shift_en,
  input  logic [7:0]  byte_in,
  input  logic        cap_en,
  input  logic [23:0] word_in,
  input  logic [1:0]  idx,
  output logic [23:0] pack_out,
  output logic [7:0]  byte_out
);
  logic [23:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (cap_en)   acc_q <= word_in;
    else if (shift_en) acc_q <= {acc_q[15:0], byte_in};
  end

  assign pack_out = fmt_pack(fmt, acc_q);
  assign byte_out = fmt_unpack(fmt, acc_q, idx);

  p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cap_en) |=> acc_q[7:0] == $past(byte_in));

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> acc_q == $past(word_in));

endmodule

// File: rtl/bytemem_dma.sv
module bytemem_dma
  import bytemem_dma_pkg::*;
#(
  parameter int OFF_W   = 14,
  parameter int PAGE_W  = 8,
  parameter int IADDR_W = 14,
  parameter int CNT_W   = 14,
  parameter int WAIT_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IADDR_W-1:0]      cfg_int_addr,
  input  logic [OFF_W-1:0]        cfg_ext_off,
  input  logic [PAGE_W-1:0]       cfg_ext_page,
  input  logic                    cfg_dir,
  input  logic [1:0]              cfg_fmt,
  input  logic                    cfg_halt,
  input  logic [WAIT_W-1:0]       cfg_wait,
  input  logic                    cnt_we,
  input  logic [CNT_W-1:0]        cnt_wdata,
  output logic [CNT_W-1:0]        cnt_rdata,
  output logic [OFF_W+PAGE_W-1:0] ext_addr,
  output logic                    ext_rd,
  output logic                    ext_wr,
  output logic                    ext_oe,
  output logic [7:0]              ext_wdata,
  input  logic [7:0]              ext_rdata,
  output logic                    mem_req,
  input  logic                    mem_gnt,
  output logic                    mem_pm,
  output logic                    mem_we,
  output logic [IADDR_W-1:0]      mem_addr,
  output logic [23:0]             mem_wdata,
  input  logic [23:0]             mem_rdata,
  output logic                    halt_cpu,
  output logic                    done_irq
);

  eng_state_e        st_q, st_d;
  logic              dir_q, halt_q, irq_q;
  xfer_fmt_e         fmt_q;
  logic [WAIT_W-1:0] wait_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        idx_q;

  // named internal events
  logic start_evt, in_byte, byte_last, grant_evt;
  logic word_bytes_last, word_done, final_word;
  logic [23:0] pack_word;
  logic [7:0]  send_byte;

  assign start_evt       = (st_q == S_IDLE) && cnt_we && (cnt_wdata != '0);
  assign in_byte         = (st_q == S_BYTE);
  assign grant_evt       = (st_q == S_STEAL) && mem_gnt;
  assign word_bytes_last = byte_last && (idx_q == fmt_bytes(fmt_q) - 2'd1);
  assign word_done       = (dir_q && word_bytes_last) || (!dir_q && grant_evt);
  assign final_word      = word_done && (cnt_q == CNT_W'(1));

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (start_evt) st_d = cfg_dir ? S_STEAL : S_BYTE;
      S_BYTE:  if (word_bytes_last) st_d = final_word ? S_IDLE : S_STEAL;
      S_STEAL: if (mem_gnt) st_d = final_word ? S_IDLE : S_BYTE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      dir_q  <= 1'b0;
      halt_q <= 1'b0;
      fmt_q  <= FMT_PM24;
      wait_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= final_word;
      if (start_evt) begin
        dir_q  <= cfg_dir;
        halt_q <= cfg_halt;
        fmt_q  <= xfer_fmt_e'(cfg_fmt);
        wait_q <= cfg_wait;
        cnt_q  <= cnt_wdata;
        idx_q  <= '0;
      end else begin
        if (word_done) cnt_q <= cnt_q - 1'b1;
        if (byte_last) idx_q <= word_bytes_last ? 2'd0 : idx_q + 2'd1;
      end
    end
  end

  bdma_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (in_byte),
    .wait_cfg (wait_q),
    .last     (byte_last)
  );

  bdma_addr_gen #(.OFF_W(OFF_W), .PAGE_W(PAGE_W), .IADDR_W(IADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_evt),
    .page_init (cfg_ext_page),
    .off_init  (cfg_ext_off),
    .int_init  (cfg_int_addr),
    .byte_step (byte_last),
    .word_step (grant_evt),
    .ext_addr  (ext_addr),
    .int_addr  (mem_addr)
  );

  bdma_packer u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt      (fmt_q),
    .shift_en (byte_last && !dir_q),
    .byte_in  (ext_rdata),
    .cap_en   (grant_evt && dir_q),
    .word_in  (mem_rdata),
    .idx      (idx_q),
    .pack_out (pack_word),
    .byte_out (send_byte)
  );

  assign ext_rd    = in_byte && !dir_q;
  assign ext_wr    = in_byte && dir_q;
  assign ext_oe    = (st_q == S_BYTE) && dir_q;
  assign ext_wdata = send_byte;
  assign mem_req   = (st_q == S_STEAL);
  assign mem_we    = mem_req && !dir_q;
  assign mem_pm    = (fmt_q == FMT_PM24);
  assign mem_wdata = pack_word;
  assign halt_cpu  = halt_q && (st_q != S_IDLE);
  assign done_irq  = irq_q;
  assign cnt_rdata = cnt_q;

  p_zero_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_IDLE) && cnt_we && (cnt_wdata == '0)) |=> (st_q == S_IDLE));

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> cnt_rdata == CNT_W'($past(cnt_rdata) - 1'b1));

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  p_irq_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (cnt_rdata == '0) && (st_q == S_IDLE));

  p_strobe_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_rd || ext_wr) && !byte_last) |=> $stable(ext_addr) && (ext_rd || ext_wr));

  p_steal_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr));

  p_dir_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_rd && (ext_wr || mem_we)));

  p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_cpu && !final_word) |=> halt_cpu);

  p_oe_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_oe && !byte_last) |=> ext_oe && $stable(ext_wdata));

endmodule

// File: tb/bytemem_dma_bench.sv
module bytemem_dma_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] cfg_int_addr = '0;
  logic [13:0] cfg_ext_off = '0;
  logic [7:0]  cfg_ext_page = '0;
  logic        cfg_dir = 1'b0;
  logic [1:0]  cfg_fmt = '0;
  logic        cfg_halt = 1'b0;
  logic [2:0]  cfg_wait = '0;
  logic        cnt_we = 1'b0;
  logic [13:0] cnt_wdata = '0;
  logic [13:0] cnt_rdata;
  logic [21:0] ext_addr;
  logic        ext_rd, ext_wr, ext_oe;
  logic [7:0]  ext_wdata, ext_rdata;
  logic        mem_req, mem_pm, mem_we;
  logic        mem_gnt = 1'b0;
  logic [13:0] mem_addr;
  logic [23:0] mem_wdata, mem_rdata;
  logic        halt_cpu, done_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ext_pat(logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
  endfunction

  function automatic logic [23:0] int_pat(logic [13:0] a);
    return {a[7:0] ^ 8'hC3, a[13:6], ~a[7:0]};
  endfunction

  function automatic int nbytes(int fmt);
    return (fmt == 0) ? 3 : (fmt == 1) ? 2 : 1;
  endfunction

  assign ext_rdata = ext_pat(ext_addr);
  assign mem_rdata = int_pat(mem_addr);

  bytemem_dma u_bytemem_dma (
    .clk(clk), .rst_n(rst_n),
    .cfg_int_addr(cfg_int_addr), .cfg_ext_off(cfg_ext_off), .cfg_ext_page(cfg_ext_page),
    .cfg_dir(cfg_dir), .cfg_fmt(cfg_fmt), .cfg_halt(cfg_halt), .cfg_wait(cfg_wait),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
    .ext_addr(ext_addr), .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_oe(ext_oe),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_pm(mem_pm), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halt_cpu(halt_cpu), .done_irq(done_irq)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected word on a load: bytes weighted most significant first
  function automatic logic [23:0] exp_load(int fmt, logic [21:0] base, int i);
    int n = nbytes(fmt);
    logic [23:0] w = '0;
    for (int k = 0; k < n; k++) begin
      logic [23:0] b = {16'h0000, ext_pat(base + 22'(i*n + k))};
      if (fmt == 2) w = w | (b << 8);
      else          w = w | (b << (8*(n-1-k)));
    end
    return w;
  endfunction

  function automatic logic [7:0] exp_store(int fmt, logic [13:0] istart, int b);
    int n = nbytes(fmt);
    int i = b / n;
    int k = b % n;
    logic [23:0] w = int_pat(istart + 14'(i));
    if (fmt == 2) return w[15:8];
    if (fmt == 3) return w[7:0];
    return 8'((w >> (8*(n-1-k))) & 24'hFF);
  endfunction

  int cur_fmt, cur_dir, cur_wait, cur_halt, cur_n, cur_words;
  logic [21:0] cur_base;
  logic [13:0] cur_istart;
  bit act = 0;
  bit seen_irq = 0;
  int words_done, strobe_cyc, strobe_total, byte_cnt, steal_cnt, irq_cnt, idle_busy;
  int gcnt = 0;

  always @(negedge clk) begin
    gcnt++;
    mem_gnt = ((gcnt % 3) != 2);
    if (done_irq) irq_cnt++;
    if (!act) begin
      if (ext_rd || ext_wr || ext_oe || mem_req || halt_cpu) idle_busy++;
    end else begin
      chk(cnt_rdata == 14'(cur_words - words_done), "R5", "live count", cnt_rdata, cur_words - words_done);
      chk(halt_cpu == (cur_halt != 0 && !done_irq), "R10", "halt level", halt_cpu, cur_halt != 0 && !done_irq);
      if (ext_rd || ext_wr) begin
        chk(ext_rd == (cur_dir == 0) && ext_wr == (cur_dir == 1) && ext_oe == (cur_dir == 1),
            "R9", "strobe kind", {ext_rd, ext_wr, ext_oe}, cur_dir);
        chk(ext_addr == cur_base + 22'(byte_cnt), "R3", "byte address", ext_addr, cur_base + 22'(byte_cnt));
        if (cur_dir == 1)
          chk(ext_wdata == exp_store(cur_fmt, cur_istart, byte_cnt), "R2", "stored byte",
              ext_wdata, exp_store(cur_fmt, cur_istart, byte_cnt));
        strobe_total++;
        strobe_cyc++;
        if (strobe_cyc == cur_wait + 1) begin
          strobe_cyc = 0;
          byte_cnt++;
          if (cur_dir == 1 && (byte_cnt % cur_n) == 0) words_done++;
        end
      end else begin
        chk(!ext_oe, "R11", "bus enable outside store strobe", ext_oe, 0);
      end
      if (mem_req && mem_gnt) begin
        chk(mem_addr == cur_istart + 14'(steal_cnt), "R8", "on-chip address", mem_addr, cur_istart + 14'(steal_cnt));
        chk(mem_pm == (cur_fmt == 0), "R1", "program memory select", mem_pm, cur_fmt == 0);
        chk(mem_we == (cur_dir == 0), "R9", "on-chip write enable", mem_we, cur_dir == 0);
        if (cur_dir == 0) begin
          chk(mem_wdata == exp_load(cur_fmt, cur_base, steal_cnt), "R1", "loaded word",
              mem_wdata, exp_load(cur_fmt, cur_base, steal_cnt));
          words_done++;
        end
        steal_cnt++;
      end
      if (done_irq) begin
        act = 0;
        seen_irq = 1;
      end
    end
  end

  task automatic run_xfer(int fmt, int dir, int w, int halt, logic [7:0] page,
                          logic [13:0] off, logic [13:0] istart, int words);
    int guard;
    @(posedge clk); #1;
    cfg_fmt = 2'(fmt); cfg_dir = dir[0]; cfg_wait = 3'(w); cfg_halt = halt[0];
    cfg_ext_page = page; cfg_ext_off = off; cfg_int_addr = istart;
    cnt_wdata = 14'(words); cnt_we = 1'b1;
    cur_fmt = fmt; cur_dir = dir; cur_wait = w; cur_halt = halt; cur_n = nbytes(fmt);
    cur_words = words; cur_base = {page, off}; cur_istart = istart;
    words_done = 0; strobe_cyc = 0; strobe_total = 0; byte_cnt = 0; steal_cnt = 0;
    irq_cnt = 0; seen_irq = 0;
    @(posedge clk); #1;
    cnt_we = 1'b0;
    cfg_wait = 3'(w + 1);
    act = 1;
    guard = 0;
    while (!seen_irq && guard < 4000) begin
      @(posedge clk);
      guard++;
    end
    if (!seen_irq) begin
      chk(0, "R6", "transfer completion", 0, 1);
      act = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(irq_cnt == 1, "R6", "completion pulses", irq_cnt, 1);
    chk(cnt_rdata == 0, "R6", "count at end", cnt_rdata, 0);
    chk(steal_cnt == words, "R8", "stolen cycles", steal_cnt, words);
    chk(strobe_total == words*cur_n*(w+1), "R7", "strobe cycles", strobe_total, words*cur_n*(w+1));
    chk(words_done == words, "R5", "finished words", words_done, words);
    chk(byte_cnt == words*cur_n, "R3", "byte accesses", byte_cnt, words*cur_n);
  endtask

  task automatic zero_write();
    @(posedge clk); #1;
    idle_busy = 0; irq_cnt = 0;
    cnt_wdata = '0; cnt_we = 1'b1; cfg_halt = 1'b1;
    @(posedge clk); #1;
    cnt_we = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    chk(idle_busy == 0, "R4", "activity after zero write", idle_busy, 0);
    chk(irq_cnt == 0, "R4", "interrupt after zero write", irq_cnt, 0);
    chk(cnt_rdata == 0, "R4", "count after zero write", cnt_rdata, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(cnt_rdata == 0 && !done_irq, "R5", "reset count and interrupt", {cnt_rdata, done_irq}, 0);
    chk(!ext_rd && !ext_wr && !ext_oe && !mem_req && !halt_cpu, "R11", "reset strobes",
        {ext_rd, ext_wr, ext_oe, mem_req, halt_cpu}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    zero_write();
    for (int fmt = 0; fmt < 4; fmt++)
      for (int dir = 0; dir < 2; dir++)
        for (int w = 0; w < 2; w++)
          run_xfer(fmt, dir, w*3, (fmt ^ dir ^ w) & 1, 8'(fmt*37 + dir*5 + w),
                   14'h3FFD, 14'h3FFE, 3 + (fmt % 2));
    run_xfer(0, 0, 1, 1, 8'hFF, 14'h3FFE, 14'h0100, 3);
    run_xfer(1, 1, 0, 0, 8'hFF, 14'h3FFF, 14'h0200, 2);
    run_xfer(3, 0, 0, 0, 8'h00, 14'h0000, 14'h0000, 1);
    zero_write();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule